// File: doc/BRIEF.md
# Hint-Gated Hybrid Branch Direction Predictor

This block predicts the direction of conditional branches with two component predictors and a chooser. One component is a per-address table of 2-bit saturating counters. The other is a table of 2-bit saturating counters whose index is the branch address XORed with a global record of recent outcomes. A third table of 2-bit counters, indexed by branch address, decides which component's answer is used when both are read.

To save table reads, the block also keeps a small tagged hint store. Each entry belongs to one branch and describes the two branches that came after it last time. For each of those two followers it records whether the simple component was right, whether only the history-based component was right, or whether both were wrong. When a branch is looked up and its entry hits, the two hints are queued. The following lookups use the queue to read only the one component that is needed, with the other component and the chooser switched off. The per-table read enables are outputs, so the surrounding pipeline can see the gating.

The fetch side presents a branch address with a valid strobe and gets a direction and three enables back in the same cycle. The execute side later reports the branch address, the real outcome and whether each component's guess was right. All training happens on that report.

Top module: `hybrid_hint_predictor`

## Requirements
- R1: The address-indexed table is indexed by the low BIM_IDX_W bits of the branch address. Its counters saturate at 3 when taken outcomes are reported and at 0 when not-taken outcomes are reported. Its prediction is the counter's upper bit.
- R2: The history-indexed table is indexed by the low GSH_IDX_W address bits XORed with the global history, both at lookup and at resolve. At each resolve the global history shifts left by one and takes the real outcome into bit 0.
- R3: When all three tables are read, a chooser counter with upper bit 1 selects the history-indexed component and upper bit 0 selects the address-indexed component. The chooser is indexed by the low SEL_IDX_W address bits.
- R4: The chooser counter moves up by one (saturating) when only the history-indexed component was right, down by one when only the address-indexed component was right, and does not move when both components agree on being right or wrong.
- R5: The hint produced by a resolve is 2'b00 if the address-indexed component was right, 2'b01 if only the history-indexed component was right, and 2'b11 if both were wrong.
- R6: A resolve writes its hint into the first slot of the entry of the previously resolved branch, allocating that entry on a miss with the second slot set to 2'b11. It writes the same hint into the second slot of the entry of the branch resolved two reports earlier, if that entry still holds that branch.
- R7: When the queued next hint is 2'b00, a lookup enables only the address-indexed table. When it is 2'b01, only the history-indexed table is enabled. When it is any other value, or when nothing is queued, all three tables are enabled. The prediction comes from the enabled component.
- R8: A lookup that hits in the hint store queues that entry's two slots. A lookup that misses moves the second queued hint to the front and leaves the second place empty.
- R9: With lookup valid low, all three enables and the prediction are 0, and the hint queue is unchanged.
- R10: Reset sets every counter to 2'b01, clears the global history, empties the hint store and the hint queue, and forgets the previously resolved branches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_en_bim | output | 1 | Read enable of the address-indexed table |
| lk_en_gsh | output | 1 | Read enable of the history-indexed table |
| lk_en_sel | output | 1 | Read enable of the chooser table |
| rs_valid | input | 1 | Resolve report strobe |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome of the resolved branch |
| rs_bim_ok | input | 1 | Address-indexed component guessed right |
| rs_gsh_ok | input | 1 | History-indexed component guessed right |

## Verification
The bench builds up a short chain of resolves so that hints land two branches back. It then replays the same branches and expects the single-component enables that those hints imply. A design that put the hints one slot off, or that indexed the hint store with the wrong branch, would show full-access or opposite enables there. An idle lookup placed between queued hints must leave the queue alone, and a design that advanced the queue on an invalid strobe would gate the next branch wrongly. The counters are driven past both ends and then stepped back once, which exposes a counter that wraps instead of holding. A lookup whose result is right only if both the XOR index and the chooser are correct catches a design that indexes the history table by address alone, or that does not train the chooser.

// File: rtl/hhp_pkg.sv
package hhp_pkg;

  typedef enum logic [1:0] {
    HINT_BIM  = 2'b00,
    HINT_GSH  = 2'b01,
    HINT_RSVD = 2'b10,
    HINT_MISS = 2'b11
  } hint_e;

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  function automatic logic [1:0] sat_step(input logic [1:0] cur, input logic inc);
    logic [1:0] res;
    res = cur;
    if (inc) begin
      if (cur != 2'b11) res = cur + 2'd1;
    end else begin
      if (cur != 2'b00) res = cur - 2'd1;
    end
    return res;
  endfunction

endpackage

// File: rtl/hhp_ctr_table.sv
module hhp_ctr_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_ctr,
  input  logic             up_en,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_inc
);
  import hhp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  logic [1:0] ctr_q [DEPTH];
  logic [1:0] ctr_d [DEPTH];

  always_comb begin
    ctr_d = ctr_q;
    if (up_en) ctr_d[up_idx] = sat_step(ctr_q[up_idx], up_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_NT;
    end else if (up_en) begin
      ctr_q <= ctr_d;
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  // R1
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_inc && ctr_q[up_idx] == 2'b11) |=> ctr_q[$past(up_idx)] == 2'b11);

  // R1
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_inc && ctr_q[up_idx] == 2'b00) |=> ctr_q[$past(up_idx)] == 2'b00);

endmodule

// File: rtl/hhp_hint_buf.sv
module hhp_hint_buf #(
  parameter int PC_W  = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output hhp_pkg::hint_e   lk_slot0,
  output hhp_pkg::hint_e   lk_slot1,
  input  logic             rs_valid,
  input  logic [PC_W-1:0]  rs_pc,
  input  hhp_pkg::hint_e   rs_hint
);
  import hhp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W;

  logic              vld_q [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  hint_e             s0_q  [DEPTH];
  hint_e             s1_q  [DEPTH];
  logic              vld_d [DEPTH];
  logic [TAG_W-1:0]  tag_d [DEPTH];
  hint_e             s0_d  [DEPTH];
  hint_e             s1_d  [DEPTH];

  // last two resolved branches
  logic              p1_vld_q, p2_vld_q;
  logic [PC_W-1:0]   p1_pc_q,  p2_pc_q;

  logic [IDX_W-1:0]  lk_idx, i1, i2;
  logic              p1_match, p2_match;
  logic              tbl_we;

  assign lk_idx   = lk_pc[IDX_W-1:0];
  assign lk_hit   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_pc[PC_W-1:IDX_W]);
  assign lk_slot0 = s0_q[lk_idx];
  assign lk_slot1 = s1_q[lk_idx];

  assign i1       = p1_pc_q[IDX_W-1:0];
  assign i2       = p2_pc_q[IDX_W-1:0];
  assign p1_match = vld_q[i1] && (tag_q[i1] == p1_pc_q[PC_W-1:IDX_W]);
  assign p2_match = vld_q[i2] && (tag_q[i2] == p2_pc_q[PC_W-1:IDX_W]);
  assign tbl_we   = rs_valid && (p1_vld_q || p2_vld_q);

  always_comb begin
    vld_d = vld_q;
    tag_d = tag_q;
    s0_d  = s0_q;
    s1_d  = s1_q;
    if (rs_valid) begin
      if (p2_vld_q && p2_match) s1_d[i2] = rs_hint;
      if (p1_vld_q) begin
        if (!p1_match) begin
          vld_d[i1] = 1'b1;
          tag_d[i1] = p1_pc_q[PC_W-1:IDX_W];
          s1_d[i1]  = HINT_MISS;
        end
        s0_d[i1] = rs_hint;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        tag_q[i] <= '0;
        s0_q[i]  <= HINT_MISS;
        s1_q[i]  <= HINT_MISS;
      end
    end else if (tbl_we) begin
      vld_q <= vld_d;
      tag_q <= tag_d;
      s0_q  <= s0_d;
      s1_q  <= s1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_vld_q <= 1'b0;
      p2_vld_q <= 1'b0;
      p1_pc_q  <= '0;
      p2_pc_q  <= '0;
    end else if (rs_valid) begin
      p2_vld_q <= p1_vld_q;
      p2_pc_q  <= p1_pc_q;
      p1_vld_q <= 1'b1;
      p1_pc_q  <= rs_pc;
    end
  end

  // R6
  hint_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && p1_vld_q) |=> (vld_q[$past(i1)] && s0_q[$past(i1)] == $past(rs_hint)));

  // R6
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> (p1_vld_q && p1_pc_q == $past(rs_pc)));

endmodule

// File: rtl/hhp_hint_gate.sv
module hhp_hint_gate (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic            lk_hit,
  input  hhp_pkg::hint_e  lk_slot0,
  input  hhp_pkg::hint_e  lk_slot1,
  output logic            en_bim,
  output logic            en_gsh,
  output logic            en_sel
);
  import hhp_pkg::*;

  logic  nxt_vld_q, nxt_vld_d;
  hint_e nxt_q,     nxt_d;
  logic  aft_vld_q, aft_vld_d;
  hint_e aft_q,     aft_d;

  always_comb begin
    en_bim = 1'b0;
    en_gsh = 1'b0;
    en_sel = 1'b0;
    if (lk_valid) begin
      if (nxt_vld_q && nxt_q == HINT_BIM) begin
        en_bim = 1'b1;
      end else if (nxt_vld_q && nxt_q == HINT_GSH) begin
        en_gsh = 1'b1;
      end else begin
        en_bim = 1'b1;
        en_gsh = 1'b1;
        en_sel = 1'b1;
      end
    end
  end

  always_comb begin
    nxt_vld_d = nxt_vld_q;
    nxt_d     = nxt_q;
    aft_vld_d = aft_vld_q;
    aft_d     = aft_q;
    if (lk_hit) begin
      nxt_vld_d = 1'b1;
      nxt_d     = lk_slot0;
      aft_vld_d = 1'b1;
      aft_d     = lk_slot1;
    end else begin
      nxt_vld_d = aft_vld_q;
      nxt_d     = aft_q;
      aft_vld_d = 1'b0;
      aft_d     = HINT_MISS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_vld_q <= 1'b0;
      nxt_q     <= HINT_MISS;
      aft_vld_q <= 1'b0;
      aft_q     <= HINT_MISS;
    end else if (lk_valid) begin
      nxt_vld_q <= nxt_vld_d;
      nxt_q     <= nxt_d;
      aft_vld_q <= aft_vld_d;
      aft_q     <= aft_d;
    end
  end

  // R7
  sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_sel |-> (en_bim && en_gsh));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(en_bim || en_gsh || en_sel));

  // R9
  queue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ($stable(nxt_vld_q) && $stable(nxt_q) && $stable(aft_vld_q)));

  // R8
  queue_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_hit) |=> (nxt_vld_q && nxt_q == $past(lk_slot0) && aft_q == $past(lk_slot1)));

endmodule

// File: rtl/hybrid_hint_predictor.sv
module hybrid_hint_predictor #(
  parameter int PC_W       = 12,
  parameter int BIM_IDX_W  = 6,
  parameter int GSH_IDX_W  = 6,
  parameter int SEL_IDX_W  = 6,
  parameter int HINT_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_en_bim,
  output logic            lk_en_gsh,
  output logic            lk_en_sel,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken,
  input  logic            rs_bim_ok,
  input  logic            rs_gsh_ok
);
  import hhp_pkg::*;

  localparam int GHR_W = GSH_IDX_W;

  logic [GHR_W-1:0]     ghr_q, ghr_d;
  logic [BIM_IDX_W-1:0] bim_lk_idx, bim_rs_idx;
  logic [GSH_IDX_W-1:0] gsh_lk_idx, gsh_rs_idx;
  logic [SEL_IDX_W-1:0] sel_lk_idx, sel_rs_idx;
  logic [1:0]           bim_ctr, gsh_ctr, sel_ctr;
  logic                 sel_up_en;
  hint_e                rs_hint;
  logic                 hb_hit;
  hint_e                hb_slot0, hb_slot1;

  assign bim_lk_idx = lk_pc[BIM_IDX_W-1:0];
  assign bim_rs_idx = rs_pc[BIM_IDX_W-1:0];
  assign gsh_lk_idx = lk_pc[GSH_IDX_W-1:0] ^ ghr_q;
  assign gsh_rs_idx = rs_pc[GSH_IDX_W-1:0] ^ ghr_q;
  assign sel_lk_idx = lk_pc[SEL_IDX_W-1:0];
  assign sel_rs_idx = rs_pc[SEL_IDX_W-1:0];
  assign sel_up_en  = rs_valid && (rs_bim_ok != rs_gsh_ok);

  always_comb begin
    if (rs_bim_ok)      rs_hint = HINT_BIM;
    else if (rs_gsh_ok) rs_hint = HINT_GSH;
    else                rs_hint = HINT_MISS;
  end

  hhp_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(bim_lk_idx), .rd_ctr(bim_ctr),
    .up_en(rs_valid), .up_idx(bim_rs_idx), .up_inc(rs_taken)
  );

  hhp_ctr_table #(.IDX_W(GSH_IDX_W)) u_gsh_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(gsh_lk_idx), .rd_ctr(gsh_ctr),
    .up_en(rs_valid), .up_idx(gsh_rs_idx), .up_inc(rs_taken)
  );

  hhp_ctr_table #(.IDX_W(SEL_IDX_W)) u_sel_tbl (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(sel_lk_idx), .rd_ctr(sel_ctr),
    .up_en(sel_up_en), .up_idx(sel_rs_idx), .up_inc(rs_gsh_ok)
  );

  hhp_hint_buf #(.PC_W(PC_W), .IDX_W(HINT_IDX_W)) u_hint_buf (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(hb_hit), .lk_slot0(hb_slot0), .lk_slot1(hb_slot1),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_hint(rs_hint)
  );

  hhp_hint_gate u_gate (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_hit(hb_hit), .lk_slot0(hb_slot0), .lk_slot1(hb_slot1),
    .en_bim(lk_en_bim), .en_gsh(lk_en_gsh), .en_sel(lk_en_sel)
  );

  always_comb begin
    lk_taken = 1'b0;
    if (lk_en_sel)      lk_taken = sel_ctr[1] ? gsh_ctr[1] : bim_ctr[1];
    else if (lk_en_gsh) lk_taken = gsh_ctr[1];
    else if (lk_en_bim) lk_taken = bim_ctr[1];
  end

  always_comb begin
    ghr_d = {ghr_q[GHR_W-2:0], rs_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ghr_q <= '0;
    else if (rs_valid) ghr_q <= ghr_d;
  end

  // R2
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> (ghr_q[0] == $past(rs_taken) && ghr_q[GHR_W-1:1] == $past(ghr_q[GHR_W-2:0])));

  // R9
  idle_pred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !lk_taken);

endmodule

// File: tb/test_hybrid_hint_predictor.sv
module test_hybrid_hint_predictor;

  localparam int PC_W = 12;
  localparam logic [1:0] K_LK = 2'd0, K_RS = 2'd1, K_IDLE = 2'd2;

  typedef struct packed {
    logic [1:0]      kind;
    logic [PC_W-1:0] pc;
    logic            tk;
    logic            bok;
    logic            gok;
    logic            epred;
    logic [2:0]      een;   // {bim, gsh, sel}
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{K_LK,   12'h011, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111}, // R10 R7 empty queue
    '{K_RS,   12'h011, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000},
    '{K_LK,   12'h022, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
    '{K_RS,   12'h022, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000},
    '{K_LK,   12'h033, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111},
    '{K_RS,   12'h033, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000},
    '{K_LK,   12'h011, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111}, // R1 trained
    '{K_LK,   12'h022, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010}, // R5 R6 hint 01
    '{K_LK,   12'h033, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100}, // R6 slot1 hint 00
    '{K_LK,   12'h011, 1'b0, 1'b0, 1'b0, 1'b1, 3'b111}, // R8 shifted 11
    '{K_IDLE, 12'h022, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000}, // R9 idle
    '{K_LK,   12'h022, 1'b0, 1'b0, 1'b0, 1'b0, 3'b010}, // R9 queue kept
    '{K_LK,   12'h044, 1'b0, 1'b0, 1'b0, 1'b0, 3'b100}, // R8 miss uses front
    '{K_LK,   12'h022, 1'b0, 1'b0, 1'b0, 1'b0, 3'b111}  // R3 R4 chooser on gshare
  };

  logic            clk;
  logic            rst_n;
  logic            lk_valid;
  logic [PC_W-1:0] lk_pc;
  logic            lk_taken, lk_en_bim, lk_en_gsh, lk_en_sel;
  logic            rs_valid;
  logic [PC_W-1:0] rs_pc;
  logic            rs_taken, rs_bim_ok, rs_gsh_ok;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  hybrid_hint_predictor i_hybrid_hint_predictor (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_en_bim(lk_en_bim), .lk_en_gsh(lk_en_gsh), .lk_en_sel(lk_en_sel),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_bim_ok(rs_bim_ok), .rs_gsh_ok(rs_gsh_ok)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (pred,bim,gsh,sel)", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] kind, input logic [PC_W-1:0] pc,
                       input logic tk, input logic bok, input logic gok);
    @(negedge clk);
    lk_valid  = (kind == K_LK);
    lk_pc     = pc;
    rs_valid  = (kind == K_RS);
    rs_pc     = pc;
    rs_taken  = tk;
    rs_bim_ok = bok;
    rs_gsh_ok = gok;
    #2;
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] pc,
                      input logic epred, input logic [2:0] een, input bit en_chk);
    apply(K_LK, pc, 1'b0, 1'b0, 1'b0);
    if (en_chk) check(req, {lk_taken, lk_en_bim, lk_en_gsh, lk_en_sel}, {epred, een});
    else        check(req, {lk_taken, 3'b000}, {epred, 3'b000});
  endtask

  task automatic do_reset();
    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_pc = '0;
    rs_valid = 1'b0; rs_pc = '0; rs_taken = 1'b0; rs_bim_ok = 1'b0; rs_gsh_ok = 1'b0;
    do_reset();

    // vector table: hint chain, gating and chooser
    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].kind, VECS[v].pc, VECS[v].tk, VECS[v].bok, VECS[v].gok);
      if (VECS[v].kind != K_RS)
        check($sformatf("R7 vec%0d", v),
              {lk_taken, lk_en_bim, lk_en_gsh, lk_en_sel}, {VECS[v].epred, VECS[v].een});
    end

    // R1 upper saturation: four increments, one decrement -> 2'b10
    for (int k = 0; k < 4; k++) apply(K_RS, 12'h005, 1'b1, 1'b0, 1'b0);
    apply(K_RS, 12'h005, 1'b0, 1'b0, 1'b0);
    look("R1 sat high", 12'h005, 1'b1, 3'b100, 1'b1);

    // R1 lower saturation, R4 agreement leaves chooser on bimodal
    for (int k = 0; k < 4; k++) apply(K_RS, 12'h005, 1'b0, 1'b0, 1'b0);
    apply(K_RS, 12'h005, 1'b1, 1'b0, 1'b0);
    look("R1 R4 sat low", 12'h005, 1'b0, 3'b111, 1'b1);

    // R10 reset mid-run clears trained counters and hints
    do_reset();
    look("R10 after reset", 12'h011, 1'b0, 3'b111, 1'b1);

    // R2 XOR index with shifted history, R3 chooser picks gshare
    apply(K_RS, 12'h001, 1'b0, 1'b0, 1'b1);
    apply(K_RS, 12'h003, 1'b1, 1'b0, 1'b0);
    apply(K_RS, 12'h003, 1'b1, 1'b0, 1'b0);
    look("R2 R3 xor index", 12'h001, 1'b1, 3'b111, 1'b1);

    // R9 idle strobe gives nothing
    apply(K_IDLE, 12'h001, 1'b0, 1'b0, 1'b0);
    check("R9 idle", {lk_taken, lk_en_bim, lk_en_gsh, lk_en_sel}, 4'b0000);

    @(negedge clk);
    lk_valid = 1'b0; rs_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule